// File: doc/BRIEF.md
# Dual-File Address Pointer Register Bank

This block keeps the pointer state of an address generation unit: a set of address registers, each paired with an offset register and a modifier register of the same index. The address registers are split into a lower file and an upper file. Each file can run one read-modify-write pointer update per clock, so two pointers can advance in the same cycle. For each file, the block shows the selected address, offset and modifier values to an external update unit. It then stores the value that unit returns.

Each update is marked pre-update or post-update. With post-update, the file's effective address is the pointer value before the update. With pre-update, it is the freshly computed value in the same cycle. Three address buses (index 0 for X data, 1 for Y data, 2 for program) each pick their effective address from either file through a per-bus source select.

A general-purpose write port can load any register of any kind. Reset sets only the modifier registers, to all ones, which is the linear-mode encoding. The update arithmetic is outside this block.

Top module: `agu_ptr_bank`

## Requirements
- R1: While reset is asserted, every modifier register holds 16'hFFFF. Address and offset registers keep their contents across a reset pulse.
- R2: A general-purpose write stores `wr_data` into the register chosen by `wr_idx` (0–7) and `wr_kind` at the next clock edge. The `wr_kind` encoding is 0 = address, 1 = offset, 2 = modifier. Kind 3 changes no register.
- R3: For each file f, `sel_addr[f]`, `sel_ofs[f]` and `sel_mod[f]` show, in the same cycle, the registers at local index `upd_idx[f]`. The lower file holds global registers 0–3 and the upper file holds 4–7.
- R4: When `upd_en[f]` is high, the selected address register of file f takes `upd_new[f]` at the clock edge. No other register changes because of that update.
- R5: Post-update (`upd_pre[f]` = 0): the effective address of file f is the address register value before the update.
- R6: Pre-update (`upd_pre[f]` = 1): the effective address of file f equals `upd_new[f]` in the same cycle.
- R7: Both files update in the same cycle, each with its own index, mode and new value, and neither disturbs the other.
- R8: When an update and a general-purpose write target the same address register in one cycle, the update value is stored. A general-purpose write to a different register in that cycle still takes effect.
- R9: Bus k carries the effective address of the lower file when `bus_src[k]` = 0, and of the upper file when it is 1.
- R10: With `upd_en[f]` low, the effective address of file f is the selected address register, and that register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (modifier registers only) |
| upd_en | input | 2 | Per-file pointer update enable |
| upd_idx | input | 2x2 | Per-file local register index |
| upd_pre | input | 2 | Per-file mode: 1 pre-update, 0 post-update |
| upd_new | input | 2x16 | Per-file updated pointer value from the update unit |
| sel_addr | output | 2x16 | Per-file selected address register |
| sel_ofs | output | 2x16 | Per-file selected offset register |
| sel_mod | output | 2x16 | Per-file selected modifier register |
| wr_en | input | 1 | General-purpose write enable |
| wr_kind | input | 2 | Register kind: 0 address, 1 offset, 2 modifier, 3 none |
| wr_idx | input | 3 | Global register index |
| wr_data | input | 16 | General-purpose write data |
| bus_src | input | 3x1 | Per-bus file select (0 lower, 1 upper) |
| bus_addr | output | 3x16 | Address buses: X, Y, program |

## Verification
The write-back and hold assertions assume that every address register was loaded before its value is observed, since address and offset registers have no reset value. The stimulus therefore fills all 24 registers through the write port right after the first reset and before any update.

The assertions also assume `upd_new` is stable during a cycle that uses pre-update. The bench drives all inputs once per cycle, away from the clock edge.

A sweep covers every pair of lower and upper indices under all four pre/post combinations, with bus routings varied between cases. The expected next pointers are computed arithmetically from the modelled offsets.

// File: rtl/agu_pkg.sv
package agu_pkg;

   typedef enum logic [1:0] {
      WK_ADDR = 2'd0,
      WK_OFS  = 2'd1,
      WK_MOD  = 2'd2,
      WK_NONE = 2'd3
   } wr_kind_e;

endpackage

// File: rtl/agu_ptr_file.sv
module agu_ptr_file
   import agu_pkg::*;
#(
   parameter int DW    = 16,
   parameter int DEPTH = 4,
   localparam int IW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          upd_en,
   input  logic [IW-1:0] upd_idx,
   input  logic          upd_pre,
   input  logic [DW-1:0] upd_new,
   input  logic          wr_en,
   input  logic [1:0]    wr_kind,
   input  logic [IW-1:0] wr_idx,
   input  logic [DW-1:0] wr_data,
   output logic [DW-1:0] rd_addr,
   output logic [DW-1:0] rd_ofs,
   output logic [DW-1:0] rd_mod,
   output logic [DW-1:0] ea
);

   generate
      if (DEPTH < 2 || (1 << IW) != DEPTH) begin : g_bad_depth
         $error("agu_ptr_file: DEPTH must be a power of two, at least 2");
      end
   endgenerate

   logic [DW-1:0] r_q [DEPTH];
   logic [DW-1:0] n_q [DEPTH];
   logic [DW-1:0] m_q [DEPTH];

   logic wr_addr_k, wr_ofs_k, wr_mod_k;
   assign wr_addr_k = wr_en && (wr_kind == WK_ADDR);
   assign wr_ofs_k  = wr_en && (wr_kind == WK_OFS);
   assign wr_mod_k  = wr_en && (wr_kind == WK_MOD);

   // pointer and offset storage: deliberately unreset
   always_ff @(posedge clk) begin
      for (int i = 0; i < DEPTH; i++) begin
         if (upd_en && upd_idx == IW'(i))
            r_q[i] <= upd_new;
         else if (wr_addr_k && wr_idx == IW'(i))
            r_q[i] <= wr_data;
         if (wr_ofs_k && wr_idx == IW'(i))
            n_q[i] <= wr_data;
      end
   end

   // modifier storage resets to linear mode
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) m_q[i] <= '1;
      end else begin
         for (int i = 0; i < DEPTH; i++)
            if (wr_mod_k && wr_idx == IW'(i)) m_q[i] <= wr_data;
      end
   end

   assign rd_addr = r_q[upd_idx];
   assign rd_ofs  = n_q[upd_idx];
   assign rd_mod  = m_q[upd_idx];
   assign ea      = (upd_en && upd_pre) ? upd_new : r_q[upd_idx];

   assert_mod_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (m_q[upd_idx] == {DW{1'b1}}));

   assert_wr_ofs_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ofs_k |=> (n_q[$past(wr_idx)] == $past(wr_data)));

   assert_upd_wb_R4: assert property (@(posedge clk) disable iff (!rst_n)
      upd_en |=> (r_q[$past(upd_idx)] == $past(upd_new)));

   assert_upd_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_en && wr_addr_k && wr_idx == upd_idx)
      |=> (r_q[$past(upd_idx)] == $past(upd_new)));

   assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!upd_en && !(wr_addr_k && wr_idx == upd_idx))
      |=> (r_q[$past(upd_idx)] === $past(r_q[upd_idx])));

endmodule

// File: rtl/agu_bus_route.sv
module agu_bus_route #(
   parameter int DW    = 16,
   parameter int NFILE = 2,
   parameter int NBUS  = 3,
   localparam int SW   = $clog2(NFILE)
) (
   input  logic [NFILE-1:0][DW-1:0] ea,
   input  logic [NBUS-1:0][SW-1:0]  src,
   output logic [NBUS-1:0][DW-1:0]  bus
);

   generate
      for (genvar k = 0; k < NBUS; k++) begin : g_bus
         if (NFILE == 2) begin : g_pair
            assign bus[k] = src[k][0] ? ea[1] : ea[0];
         end else begin : g_wide
            always_comb begin
               bus[k] = '0;
               for (int f = 0; f < NFILE; f++)
                  if (src[k] == SW'(f)) bus[k] = ea[f];
            end
         end
      end
   endgenerate

endmodule

// File: rtl/agu_ptr_bank.sv
module agu_ptr_bank
   import agu_pkg::*;
#(
   parameter int DW    = 16,
   parameter int NPTR  = 8,
   parameter int NFILE = 2,
   parameter int NBUS  = 3
) (
   input  logic                                        clk,
   input  logic                                        rst_n,
   input  logic [NFILE-1:0]                            upd_en,
   input  logic [NFILE-1:0][$clog2(NPTR/NFILE)-1:0]    upd_idx,
   input  logic [NFILE-1:0]                            upd_pre,
   input  logic [NFILE-1:0][DW-1:0]                    upd_new,
   output logic [NFILE-1:0][DW-1:0]                    sel_addr,
   output logic [NFILE-1:0][DW-1:0]                    sel_ofs,
   output logic [NFILE-1:0][DW-1:0]                    sel_mod,
   input  logic                                        wr_en,
   input  logic [1:0]                                  wr_kind,
   input  logic [$clog2(NPTR)-1:0]                     wr_idx,
   input  logic [DW-1:0]                               wr_data,
   input  logic [NBUS-1:0][$clog2(NFILE)-1:0]          bus_src,
   output logic [NBUS-1:0][DW-1:0]                     bus_addr
);

   localparam int PER_FILE = NPTR / NFILE;
   localparam int IW       = $clog2(PER_FILE);
   localparam int GW       = $clog2(NPTR);

   generate
      if (NFILE < 2 || (1 << $clog2(NFILE)) != NFILE) begin : g_bad_nfile
         $error("agu_ptr_bank: NFILE must be a power of two, at least 2");
      end
      if (NPTR % NFILE != 0 || PER_FILE < 2) begin : g_bad_nptr
         $error("agu_ptr_bank: NPTR must split into files of two or more");
      end
      if (NBUS < 1) begin : g_bad_nbus
         $error("agu_ptr_bank: NBUS must be at least 1");
      end
   endgenerate

   logic [NFILE-1:0][DW-1:0] ea;
   logic [IW-1:0]            wr_local;
   logic [GW-IW-1:0]         wr_file;

   assign wr_local = wr_idx[IW-1:0];
   assign wr_file  = wr_idx[GW-1:IW];

   generate
      for (genvar f = 0; f < NFILE; f++) begin : g_file
         logic wr_here;
         assign wr_here = wr_en && (wr_file == (GW-IW)'(f));

         agu_ptr_file #(
            .DW    (DW),
            .DEPTH (PER_FILE)
         ) u_file (
            .clk     (clk),
            .rst_n   (rst_n),
            .upd_en  (upd_en[f]),
            .upd_idx (upd_idx[f]),
            .upd_pre (upd_pre[f]),
            .upd_new (upd_new[f]),
            .wr_en   (wr_here),
            .wr_kind (wr_kind),
            .wr_idx  (wr_local),
            .wr_data (wr_data),
            .rd_addr (sel_addr[f]),
            .rd_ofs  (sel_ofs[f]),
            .rd_mod  (sel_mod[f]),
            .ea      (ea[f])
         );
      end
   endgenerate

   agu_bus_route #(
      .DW    (DW),
      .NFILE (NFILE),
      .NBUS  (NBUS)
   ) u_route (
      .ea  (ea),
      .src (bus_src),
      .bus (bus_addr)
   );

   generate
      for (genvar k = 0; k < NBUS; k++) begin : g_bus_chk
         for (genvar f = 0; f < NFILE; f++) begin : g_src
            assert_post_bus_R5: assert property (@(posedge clk) disable iff (!rst_n)
               (bus_src[k] == f && upd_en[f] && !upd_pre[f])
               |-> (bus_addr[k] == sel_addr[f]));
            assert_pre_bus_R6: assert property (@(posedge clk) disable iff (!rst_n)
               (bus_src[k] == f && upd_en[f] && upd_pre[f])
               |-> (bus_addr[k] == upd_new[f]));
         end
      end
   endgenerate

endmodule

// File: tb/tb_agu_ptr_bank.sv
module tb_agu_ptr_bank;

   logic                 clk = 1'b0;
   logic                 rst_n;
   logic [1:0]           upd_en;
   logic [1:0][1:0]      upd_idx;
   logic [1:0]           upd_pre;
   logic [1:0][15:0]     upd_new;
   logic [1:0][15:0]     sel_addr, sel_ofs, sel_mod;
   logic                 wr_en;
   logic [1:0]           wr_kind;
   logic [2:0]           wr_idx;
   logic [15:0]          wr_data;
   logic [2:0][0:0]      bus_src;
   logic [2:0][15:0]     bus_addr;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   logic [15:0] mr [8];
   logic [15:0] mn [8];
   logic [15:0] mm [8];

   always #2 clk = ~clk;

   agu_ptr_bank dut (
      .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .upd_idx(upd_idx),
      .upd_pre(upd_pre), .upd_new(upd_new), .sel_addr(sel_addr),
      .sel_ofs(sel_ofs), .sel_mod(sel_mod), .wr_en(wr_en), .wr_kind(wr_kind),
      .wr_idx(wr_idx), .wr_data(wr_data), .bus_src(bus_src), .bus_addr(bus_addr)
   );

   task automatic chk(input bit ok, input string req, input logic [15:0] act,
                      input logic [15:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic idle();
      upd_en = 2'b00; upd_pre = 2'b00; wr_en = 1'b0; wr_kind = 2'd3;
   endtask

   task automatic gp_write(input logic [1:0] kind, input int idx, input logic [15:0] d);
      @(negedge clk);
      idle();
      wr_en = 1'b1; wr_kind = kind; wr_idx = 3'(idx); wr_data = d;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // read all registers back through the selection ports (R3)
   task automatic readback_all(input string req);
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         idle();
         upd_idx[0] = 2'(i); upd_idx[1] = 2'(i);
         #1;
         for (int f = 0; f < 2; f++) begin
            chk(sel_addr[f] == mr[4*f+i], req, sel_addr[f], mr[4*f+i]);
            chk(sel_ofs[f]  == mn[4*f+i], req, sel_ofs[f],  mn[4*f+i]);
            chk(sel_mod[f]  == mm[4*f+i], req, sel_mod[f],  mm[4*f+i]);
         end
      end
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         n_bad++; n_chk++;
         $display("FAIL watchdog: actual timeout expected finish");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      idle();
      upd_idx = '0; upd_new = '0; wr_idx = '0; wr_data = '0; bus_src = '0;
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      // R1: modifiers read all ones during reset
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         upd_idx[0] = 2'(i); upd_idx[1] = 2'(i);
         #1;
         chk(sel_mod[0] == 16'hFFFF, "R1", sel_mod[0], 16'hFFFF);
         chk(sel_mod[1] == 16'hFFFF, "R1", sel_mod[1], 16'hFFFF);
      end
      @(negedge clk);
      rst_n = 1'b1;

      // R2: fill every register through the write port
      for (int i = 0; i < 8; i++) begin
         mr[i] = 16'h1000 * 16'(i) + 16'h0040;
         mn[i] = 16'(i + 1) * 16'h0003;
         mm[i] = 16'h0F00 + 16'(i);
         gp_write(2'd0, i, mr[i]);
         gp_write(2'd1, i, mn[i]);
         gp_write(2'd2, i, mm[i]);
      end
      readback_all("R2");
      // R2: kind 3 leaves registers untouched
      gp_write(2'd3, 2, 16'hDEAD);
      gp_write(2'd3, 5, 16'hBEEF);
      readback_all("R2");

      // R1: reset pulse clears modifiers only
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < 8; i++) mm[i] = 16'hFFFF;
      readback_all("R1");
      for (int i = 0; i < 8; i++) begin
         mm[i] = 16'h0020 + 16'(i);
         gp_write(2'd2, i, mm[i]);
      end

      // R4-R7, R9: sweep both files, all index pairs and modes
      for (int a = 0; a < 4; a++) begin
         for (int b = 0; b < 4; b++) begin
            for (int md = 0; md < 4; md++) begin
               logic [15:0] nlo, nhi, elo, ehi, expb;
               nlo = mr[a] + mn[a];
               nhi = mr[4+b] - mn[4+b];
               elo = md[0] ? nlo : mr[a];
               ehi = md[1] ? nhi : mr[4+b];
               @(negedge clk);
               idle();
               upd_en = 2'b11;
               upd_idx[0] = 2'(a); upd_idx[1] = 2'(b);
               upd_pre = 2'(md);
               upd_new[0] = nlo; upd_new[1] = nhi;
               bus_src = 3'(a + 3*b + md);
               #1;
               chk(sel_addr[0] == mr[a],   "R3", sel_addr[0], mr[a]);
               chk(sel_ofs[1]  == mn[4+b], "R3", sel_ofs[1],  mn[4+b]);
               chk(sel_mod[1]  == mm[4+b], "R3", sel_mod[1],  mm[4+b]);
               for (int k = 0; k < 3; k++) begin
                  expb = bus_src[k][0] ? ehi : elo;
                  chk(bus_addr[k] == expb,
                      md[bus_src[k][0]] ? "R6/R9" : "R5/R9", bus_addr[k], expb);
               end
               @(posedge clk);
               mr[a] = nlo; mr[4+b] = nhi;
               @(negedge clk);
               upd_en = 2'b00;
               #1;
               chk(sel_addr[0] == mr[a],   "R4/R7", sel_addr[0], mr[a]);
               chk(sel_addr[1] == mr[4+b], "R4/R7", sel_addr[1], mr[4+b]);
            end
         end
      end
      readback_all("R4");

      // R8: update beats a write to the same register
      @(negedge clk);
      idle();
      upd_en = 2'b01; upd_idx[0] = 2'd1; upd_new[0] = 16'h5A5A;
      wr_en = 1'b1; wr_kind = 2'd0; wr_idx = 3'd1; wr_data = 16'hC3C3;
      @(posedge clk);
      mr[1] = 16'h5A5A;
      // R8: update and write to another register both land
      @(negedge clk);
      upd_en = 2'b01; upd_idx[0] = 2'd2; upd_new[0] = 16'h1234;
      wr_en = 1'b1; wr_kind = 2'd0; wr_idx = 3'd6; wr_data = 16'h4321;
      @(posedge clk);
      mr[2] = 16'h1234; mr[6] = 16'h4321;
      @(negedge clk);
      idle();
      upd_idx[0] = 2'd1;
      #1;
      chk(sel_addr[0] == mr[1], "R8", sel_addr[0], mr[1]);
      readback_all("R8");

      // R10: no update -> bus shows register, register holds
      @(negedge clk);
      idle();
      upd_pre = 2'b11; upd_new[0] = 16'hFFF0; upd_new[1] = 16'hFFF1;
      upd_idx[0] = 2'd3; upd_idx[1] = 2'd0;
      bus_src = 3'b010;
      #1;
      chk(bus_addr[0] == mr[3], "R10", bus_addr[0], mr[3]);
      chk(bus_addr[1] == mr[4], "R10", bus_addr[1], mr[4]);
      chk(bus_addr[2] == mr[3], "R10", bus_addr[2], mr[3]);
      @(posedge clk);
      @(negedge clk);
      #1;
      chk(sel_addr[0] == mr[3], "R10", sel_addr[0], mr[3]);
      chk(sel_addr[1] == mr[4], "R10", sel_addr[1], mr[4]);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule